// File: doc/BRIEF.md
# Timed Ramp Packet Framer

The framer builds one packet at a time on a 64-bit streaming master port that uses valid/ready/last handshaking. A single-cycle start pulse loads the packet description: the packet kind, an end-of-burst flag, a flag that asks for a timestamp beat, 16-bit source and destination stream identifiers, a 64-bit timestamp, the number of payload words, and the first value and step of a 64-bit arithmetic ramp.

The framer sends a header beat first. If a timestamp was requested, the timestamp beat follows the header. The payload words come last. The framer computes the header's byte-length field from the payload count and the timestamp option. It stamps each packet with a 12-bit sequence number, which it advances once the packet's last beat has been accepted. The downstream receiver may hold off any beat. The framer keeps the beat unchanged until the receiver takes it.

Typical use is as a traffic source: a packet generator for a stream fabric, or a test pattern injector that a receiver can check word by word.

Top module: `ramp_pkt_framer`

## Requirements
- R1: The header beat carries the kind in bits [63:62], the timestamp flag in [61], the end-of-burst flag in [60], the sequence number in [59:48], the byte length in [47:32], the source identifier in [31:16] and the destination identifier in [15:0].
- R2: The kind field is copied unchanged into the header, with the codes 2'b00 data, 2'b01 flow control, 2'b10 command and 2'b11 response.
- R3: The byte length equals eight times the payload word count, plus 16 when the timestamp flag is set or plus 8 when it is clear.
- R4: When the timestamp flag is set, the beat right after the header carries the 64-bit timestamp. When the flag is clear, no timestamp beat is sent.
- R5: Payload word k, counted from 0, equals the ramp start plus k times the ramp step, modulo 2^64.
- R6: Last is high only on the final beat of a packet. That beat is the last payload word. With no payload it is the timestamp beat, or the header beat when there is no timestamp either (length 8).
- R7: While valid is high and ready is low, valid, data and last hold their values. The framer moves to the next beat only on a cycle where valid and ready are both high.
- R8: The sequence number is 0 after reset and goes up by one, modulo 4096, after each packet completes.
- R9: A start pulse is taken only while the framer is idle. A start pulse while busy changes no output. Busy goes high in the cycle after acceptance and stays high until the last beat transfers.
- R10: After reset, valid, last and busy are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; loads the packet description when idle |
| kind_i | input | 2 | Packet kind code |
| eob_i | input | 1 | End-of-burst flag for the header |
| timed_i | input | 1 | Request a timestamp beat |
| src_id_i | input | 16 | Source stream identifier |
| dst_id_i | input | 16 | Destination stream identifier |
| stamp_i | input | 64 | Timestamp value |
| nwords_i | input | 12 | Payload word count |
| ramp_base_i | input | 64 | First payload value |
| ramp_step_i | input | 64 | Step between payload values |
| busy_o | output | 1 | Packet in progress |
| m_tdata | output | 64 | Stream data |
| m_tvalid | output | 1 | Stream valid |
| m_tlast | output | 1 | Last beat of packet |
| m_tready | input | 1 | Stream ready from the receiver |

## Verification
The embedded assertions check the following on every cycle:
- The beat holds steady under backpressure.
- The sequence counter steps by exactly one per completed packet and holds otherwise.
- The ramp accumulator moves by the latched step on each payload beat.
- Valid drops right after a last beat.
- Busy and valid agree.

The bench's scenarios are what show the content of each packet. A scoreboard checks header field placement and the length arithmetic for both timestamp settings. It checks where the timestamp beat sits, ramp wraparound past 2^64, and the placement of last in packets with no payload. It also confirms that a start pulse arriving mid-packet adds no beats, and that the sequence number wraps from 4095 to 0 after thousands of packets.

// File: rtl/rpf_pkg.sv
package rpf_pkg;

  typedef enum logic [1:0] {
    PK_DATA = 2'b00,
    PK_FLOW = 2'b01,
    PK_CMD  = 2'b10,
    PK_RESP = 2'b11
  } pkt_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HDR,
    ST_TIME,
    ST_BODY
  } fr_state_e;

  typedef struct packed {
    logic [1:0]  kind;
    logic        timed;
    logic        eob;
    logic [11:0] seq;
    logic [15:0] len;
    logic [15:0] src;
    logic [15:0] dst;
  } hdr_word_t;

endpackage

// File: rtl/rpf_hdr_pack.sv
module rpf_hdr_pack #(
  parameter int CNT_W = 12,
  parameter int SEQ_W = 12
) (
  input  logic [1:0]       kind,
  input  logic             timed,
  input  logic             eob,
  input  logic [SEQ_W-1:0] seq,
  input  logic [CNT_W-1:0] nwords,
  input  logic [15:0]      src,
  input  logic [15:0]      dst,
  output logic [63:0]      word
);
  import rpf_pkg::*;

  localparam int LEN_W = 16;

  hdr_word_t        hw;
  logic [LEN_W-1:0] body_bytes;
  logic [LEN_W-1:0] lead_bytes;

  always_comb begin
    body_bytes = LEN_W'(nwords) << 3;
    lead_bytes = timed ? LEN_W'(16) : LEN_W'(8);
    hw.kind  = kind;
    hw.timed = timed;
    hw.eob   = eob;
    hw.seq   = 12'(seq);
    hw.len   = body_bytes + lead_bytes;
    hw.src   = src;
    hw.dst   = dst;
    word     = hw;
  end

endmodule

// File: rtl/rpf_seq_ctr.sv
module rpf_seq_ctr #(
  parameter int SEQ_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [SEQ_W-1:0] seq
);

  always_ff @(posedge clk) begin
    if (rst) seq <= '0;
    else if (inc) seq <= seq + 1'b1;
  end

  assert_seq_step_R8: assert property (@(posedge clk) disable iff (rst)
    inc |=> seq == $past(seq) + 1'b1);

  assert_seq_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(seq));

endmodule

// File: rtl/rpf_ramp_gen.sv
module rpf_ramp_gen #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         adv,
  input  logic [W-1:0] base,
  input  logic [W-1:0] step,
  output logic [W-1:0] cur
);

  logic [W-1:0] step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur    <= '0;
      step_q <= '0;
    end else if (load) begin
      cur    <= base;
      step_q <= step;
    end else if (adv) begin
      cur    <= cur + step_q;
    end
  end

  assert_ramp_advance_R5: assert property (@(posedge clk) disable iff (rst)
    (adv && !load) |=> cur == $past(cur) + $past(step_q));

endmodule

// File: rtl/ramp_pkt_framer.sv
module ramp_pkt_framer #(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 12,
  parameter int SEQ_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [1:0]        kind_i,
  input  logic              eob_i,
  input  logic              timed_i,
  input  logic [15:0]       src_id_i,
  input  logic [15:0]       dst_id_i,
  input  logic [DATA_W-1:0] stamp_i,
  input  logic [CNT_W-1:0]  nwords_i,
  input  logic [DATA_W-1:0] ramp_base_i,
  input  logic [DATA_W-1:0] ramp_step_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] m_tdata,
  output logic              m_tvalid,
  output logic              m_tlast,
  input  logic              m_tready
);
  import rpf_pkg::*;

  fr_state_e         state;
  logic              timed_q;
  logic [DATA_W-1:0] stamp_q;
  logic [CNT_W-1:0]  remain;
  logic [SEQ_W-1:0]  seq;
  logic [63:0]       hdr_word;
  logic [DATA_W-1:0] ramp_cur;
  logic              beat;
  logic              accept;
  logic              go_time;
  logic              ramp_adv;

  assign beat     = m_tvalid & m_tready;
  assign accept   = (state == ST_IDLE) & start_i;
  assign go_time  = (state == ST_HDR) & timed_q;
  assign ramp_adv = beat & ~m_tlast & ~go_time;
  assign busy_o   = (state != ST_IDLE);

  rpf_hdr_pack #(.CNT_W(CNT_W), .SEQ_W(SEQ_W)) u_hdr (
    .kind   (kind_i),
    .timed  (timed_i),
    .eob    (eob_i),
    .seq    (seq),
    .nwords (nwords_i),
    .src    (src_id_i),
    .dst    (dst_id_i),
    .word   (hdr_word)
  );

  rpf_seq_ctr #(.SEQ_W(SEQ_W)) u_seq (
    .clk (clk),
    .rst (rst),
    .inc (beat & m_tlast),
    .seq (seq)
  );

  rpf_ramp_gen #(.W(DATA_W)) u_ramp (
    .clk  (clk),
    .rst  (rst),
    .load (accept),
    .adv  (ramp_adv),
    .base (ramp_base_i),
    .step (ramp_step_i),
    .cur  (ramp_cur)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      timed_q  <= 1'b0;
      stamp_q  <= '0;
      remain   <= '0;
      m_tdata  <= '0;
      m_tvalid <= 1'b0;
      m_tlast  <= 1'b0;
    end else if (state == ST_IDLE) begin
      if (start_i) begin
        m_tdata  <= DATA_W'(hdr_word);
        m_tvalid <= 1'b1;
        m_tlast  <= (nwords_i == '0) && !timed_i;
        timed_q  <= timed_i;
        stamp_q  <= stamp_i;
        remain   <= nwords_i;
        state    <= ST_HDR;
      end
    end else if (beat) begin
      if (m_tlast) begin
        m_tvalid <= 1'b0;
        m_tlast  <= 1'b0;
        state    <= ST_IDLE;
      end else if (go_time) begin
        m_tdata <= stamp_q;
        m_tlast <= (remain == '0);
        state   <= ST_TIME;
      end else begin
        m_tdata <= ramp_cur;
        m_tlast <= (remain == CNT_W'(1));
        remain  <= remain - 1'b1;
        state   <= ST_BODY;
      end
    end
  end

  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

  assert_drop_after_last_R6: assert property (@(posedge clk) disable iff (rst)
    (beat && m_tlast) |=> !m_tvalid);

  assert_busy_tracks_valid_R9: assert property (@(posedge clk) disable iff (rst)
    busy_o == m_tvalid);

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !beat) |=> $stable(m_tdata));

  assert_last_needs_valid_R6: assert property (@(posedge clk) disable iff (rst)
    m_tlast |-> m_tvalid);

endmodule

// File: tb/sim_ramp_pkt_framer.sv
module sim_ramp_pkt_framer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [1:0]  kind_i = '0;
  logic        eob_i = 1'b0;
  logic        timed_i = 1'b0;
  logic [15:0] src_id_i = '0;
  logic [15:0] dst_id_i = '0;
  logic [63:0] stamp_i = '0;
  logic [11:0] nwords_i = '0;
  logic [63:0] ramp_base_i = '0;
  logic [63:0] ramp_step_i = '0;
  logic        busy_o;
  logic [63:0] m_tdata;
  logic        m_tvalid;
  logic        m_tlast;
  logic        m_tready = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [11:0] exp_seq = '0;
  bit   bp_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  logic [63:0] q_data[$];
  logic        q_last[$];
  string       q_tag[$];

  logic        hold_pend = 1'b0;
  logic [63:0] hold_data;
  logic        hold_last;

  always #5 clk = ~clk;

  ramp_pkt_framer u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .kind_i(kind_i), .eob_i(eob_i),
    .timed_i(timed_i), .src_id_i(src_id_i), .dst_id_i(dst_id_i), .stamp_i(stamp_i),
    .nwords_i(nwords_i), .ramp_base_i(ramp_base_i), .ramp_step_i(ramp_step_i),
    .busy_o(busy_o), .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tlast(m_tlast),
    .m_tready(m_tready)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // ready pattern, driven just after the rising edge
  always @(posedge clk) begin
    cycles <= cycles + 1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    #2 m_tready = bp_mode ? lfsr[0] : 1'b1;
  end

  always @(posedge clk) begin
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  // monitor: samples at the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      if (hold_pend) begin
        check(m_tvalid && m_tdata == hold_data && m_tlast == hold_last,
              "R7 hold under backpressure", m_tdata, hold_data);
      end
      hold_pend = m_tvalid && !m_tready;
      hold_data = m_tdata;
      hold_last = m_tlast;
      if (m_tvalid && m_tready) begin
        if (q_data.size() == 0) begin
          check(1'b0, "R9 unexpected beat", m_tdata, 64'd0);
        end else begin
          logic [63:0] ed;
          logic        el;
          string       et;
          ed = q_data.pop_front();
          el = q_last.pop_front();
          et = q_tag.pop_front();
          check(m_tdata == ed, et, m_tdata, ed);
          check(m_tlast == el, "R6 last placement", 64'(m_tlast), 64'(el));
        end
      end
    end
  end

  task automatic send_pkt(input logic [1:0] kind, input logic eob, input logic timed,
                          input logic [15:0] src, input logic [15:0] dst,
                          input logic [63:0] stamp, input int n,
                          input logic [63:0] base, input logic [63:0] step);
    logic [15:0] len;
    logic [63:0] w;
    while (busy_o) @(negedge clk);
    len = 16'(n * 8 + (timed ? 16 : 8));
    q_data.push_back({kind, timed, eob, exp_seq, len, src, dst});
    q_last.push_back((n == 0) && !timed);
    q_tag.push_back("R1 R2 R3 R8 header");
    if (timed) begin
      q_data.push_back(stamp);
      q_last.push_back(n == 0);
      q_tag.push_back("R4 timestamp beat");
    end
    w = base;
    for (int k = 0; k < n; k++) begin
      q_data.push_back(w);
      q_last.push_back(k == n - 1);
      q_tag.push_back("R5 ramp word");
      w = w + step;
    end
    exp_seq = exp_seq + 1'b1;
    kind_i = kind; eob_i = eob; timed_i = timed; src_id_i = src; dst_id_i = dst;
    stamp_i = stamp; nwords_i = 12'(n); ramp_base_i = base; ramp_step_i = step;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R9 busy after accept", 64'(busy_o), 64'd1);
  endtask

  task automatic drain();
    while (busy_o || q_data.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(m_tvalid == 1'b0 && m_tlast == 1'b0 && busy_o == 1'b0, "R10 reset state",
          {61'd0, m_tvalid, m_tlast, busy_o}, 64'd0);

    send_pkt(2'b00, 1'b0, 1'b0, 16'h1234, 16'h5678, 64'd0, 4, 64'd100, 64'd7);
    drain();
    send_pkt(2'b10, 1'b1, 1'b1, 16'hBEEF, 16'h0042, 64'h0123_4567_89AB_CDEF, 3, 64'd5, 64'd1000);
    drain();
    send_pkt(2'b01, 1'b0, 1'b0, 16'h0001, 16'h0002, 64'd0, 0, 64'd0, 64'd0);
    drain();
    send_pkt(2'b11, 1'b1, 1'b1, 16'hFFFF, 16'h0000, 64'hDEAD_0000_BEEF_0001, 0, 64'd0, 64'd0);
    drain();

    bp_mode = 1'b1;
    send_pkt(2'b00, 1'b1, 1'b0, 16'h00AA, 16'h0055, 64'd0, 5, 64'hFFFF_FFFF_FFFF_FFFE, 64'd1);
    drain();
    send_pkt(2'b10, 1'b0, 1'b1, 16'h0777, 16'h0888, 64'h1111_2222_3333_4444, 6,
             64'h8000_0000_0000_0000, 64'h9000_0000_0000_0001);
    // start pulse while busy: must add no beats
    kind_i = 2'b11; nwords_i = 12'd9; timed_i = 1'b1;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    drain();
    repeat (6) @(negedge clk);
    check(m_tvalid == 1'b0 && busy_o == 1'b0, "R9 start ignored while busy",
          {62'd0, m_tvalid, busy_o}, 64'd0);
    bp_mode = 1'b0;

    // run the sequence number up to its wrap
    while (exp_seq != 12'd4095) begin
      send_pkt(2'b01, 1'b0, 1'b0, 16'h0003, 16'h0004, 64'd0, 0, 64'd0, 64'd0);
    end
    send_pkt(2'b00, 1'b0, 1'b0, 16'h0009, 16'h000A, 64'd0, 1, 64'd1, 64'd1);
    drain();
    check(exp_seq == 12'd0, "R8 model wrapped", 64'(exp_seq), 64'd0);
    send_pkt(2'b00, 1'b0, 1'b1, 16'h000B, 16'h000C, 64'd77, 2, 64'd3, 64'd3);
    drain();
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule